// File: doc/BRIEF.md
# Shared Cache Coherence Directory

This block is the coherence controller of a shared, inclusive second-level cache that sits behind several private caches. Every line of the direct-mapped shared array holds a tag, a dirty flag, a data word and a presence vector with one bit per core. The presence bits record which private caches may hold a copy of the line.

Cores send plain reads and read-for-ownership requests. The block uses the presence bits to decide whether a snoop is needed and which cores receive it. It then answers with a global-observation message that carries the granted state, and sends the data one cycle later. Misses fetch the line from memory. When a line with holders is displaced, those holders get a back-invalidate, which keeps the shared cache inclusive. Modified data returned by that back-invalidate is written to memory before the new line is read.

The block handles one request at a time. A request that arrives while another is being resolved (looked up, snooped or fetched) waits at the request port.

Top module: `ccd_directory`

## Requirements
- R1: After reset every line is invalid and every presence bit is clear. `req_ready` is 1, and `go_valid`, `fill_valid`, `snp_valid`, `mem_rd_valid` and `mem_wb_valid` are all 0. The first access to any address therefore reads memory.
- R2: A read that misses sends one memory read with the request address. It is granted E (code 2), with the memory data, and only the requester's presence bit is set afterwards.
- R3: A read that hits, where the presence bits show exactly one other holder, snoops only that core with `snp_inv`=0 (share). Modified data returned by the snoop is the data filled. The grant is S (code 1).
- R4: A read that hits, where two or more other cores hold the line, sends no snoop and is granted S. The requester's bit is added to the existing bits.
- R5: A read-for-ownership that hits, where other holders exist, snoop-invalidates all of those cores in one snoop with `snp_inv`=1. The grant is M (code 3), and afterwards only the requester's bit remains set. A read-for-ownership that misses is granted M after the memory read.
- R6: A hit where no other core's bit is set sends no snoop. A read is granted E and a read-for-ownership is granted M.
- R7: A miss that displaces a valid line snoop-invalidates every core whose bit is set, using the victim's address. If the snoop returns modified data, or if the shared copy is dirty, one memory writeback of the newest data to the victim address comes before the memory read. A clean victim produces no writeback.
- R8: Each request receives exactly one `go_valid` pulse, carrying the core and the state (I=0, S=1, E=2, M=3). A `fill_valid` pulse to the same core follows in the next cycle.
- R9: `req_ready` falls in the cycle after a request is accepted and stays low until the fill cycle. Only one request is ever in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_core | input | CORE_W | Requesting core |
| req_rfo | input | 1 | 1 = read-for-ownership, 0 = read |
| req_addr | input | TAG_W+IDX_W | Line address {tag, index} |
| snp_valid | output | 1 | Snoop issue pulse |
| snp_addr | output | TAG_W+IDX_W | Snooped line address |
| snp_mask | output | N_CORES | Cores addressed by the snoop |
| snp_inv | output | 1 | 1 = invalidate, 0 = downgrade to shared |
| snp_ack | input | 1 | Combined snoop response |
| snp_dirty | input | 1 | Response carries modified data |
| snp_data | input | DATA_W | Modified data |
| mem_rd_valid | output | 1 | Memory read request pulse |
| mem_rd_addr | output | TAG_W+IDX_W | Memory read address |
| mem_rd_done | input | 1 | Memory read data valid |
| mem_rd_data | input | DATA_W | Memory read data |
| mem_wb_valid | output | 1 | Memory writeback pulse |
| mem_wb_addr | output | TAG_W+IDX_W | Writeback address |
| mem_wb_data | output | DATA_W | Writeback data |
| go_valid | output | 1 | Global-observation pulse |
| go_core | output | CORE_W | Core receiving the observation |
| go_state | output | 2 | Granted state |
| fill_valid | output | 1 | Fill data pulse |
| fill_core | output | CORE_W | Core receiving the fill |
| fill_data | output | DATA_W | Line data |

## Verification
The assertions check, on every cycle, several properties. A request snoop never targets the requester. Every issued snoop addresses at least one core, and an eviction snoop always invalidates. A global observation is always followed by its fill to the same core. E and M grants leave exactly one presence bit set, while an S grant leaves at least two. Memory reads and writebacks never overlap. Other behaviour can only be shown by the bench's request sequences: the presence vector evolving over successive requests to one line, dirty snoop data being forwarded to a later requester, and a writeback occurring only for a dirty victim.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [2:0] {
    F_IDLE, F_LOOK, F_SNPW, F_WB, F_MRDW, F_GO, F_FILL
  } fsm_t;
endpackage

// File: rtl/ccd_line_store.sv
module ccd_line_store #(
  parameter int IDX_W = 4,
  parameter int WIDTH = 43
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/ccd_policy.sv
module ccd_policy
  import ccd_pkg::*;
#(
  parameter int N_CORES = 4
) (
  input  logic               hit,
  input  logic               rfo,
  input  logic [N_CORES-1:0] req_oh,
  input  logic [N_CORES-1:0] cvb,
  output logic               snoop,
  output logic [N_CORES-1:0] mask,
  output logic               inv,
  output mesi_t              grant,
  output logic [N_CORES-1:0] new_cvb
);
  localparam int CNT_W = $clog2(N_CORES + 1);

  logic [N_CORES-1:0] others;
  logic [CNT_W-1:0]   n_oth;

  always_comb begin
    others = hit ? (cvb & ~req_oh) : '0;
    n_oth  = '0;
    for (int i = 0; i < N_CORES; i++) n_oth = n_oth + CNT_W'(others[i]);
  end

  always_comb begin
    mask  = others;
    inv   = rfo;
    snoop = hit && (rfo ? (others != '0) : (n_oth == CNT_W'(1)));
    if (!hit || rfo) grant = rfo ? ST_M : ST_E;
    else             grant = (others == '0) ? ST_E : ST_S;
    new_cvb = (!hit || rfo) ? req_oh : (cvb | req_oh);
  end
endmodule

// File: rtl/ccd_directory.sv
module ccd_directory
  import ccd_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 32,
  parameter int CORE_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [CORE_W-1:0]      req_core,
  input  logic                   req_rfo,
  input  logic [TAG_W+IDX_W-1:0] req_addr,
  output logic                   snp_valid,
  output logic [TAG_W+IDX_W-1:0] snp_addr,
  output logic [N_CORES-1:0]     snp_mask,
  output logic                   snp_inv,
  input  logic                   snp_ack,
  input  logic                   snp_dirty,
  input  logic [DATA_W-1:0]      snp_data,
  output logic                   mem_rd_valid,
  output logic [TAG_W+IDX_W-1:0] mem_rd_addr,
  input  logic                   mem_rd_done,
  input  logic [DATA_W-1:0]      mem_rd_data,
  output logic                   mem_wb_valid,
  output logic [TAG_W+IDX_W-1:0] mem_wb_addr,
  output logic [DATA_W-1:0]      mem_wb_data,
  output logic                   go_valid,
  output logic [CORE_W-1:0]      go_core,
  output logic [1:0]             go_state,
  output logic                   fill_valid,
  output logic [CORE_W-1:0]      fill_core,
  output logic [DATA_W-1:0]      fill_data
);
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam int ENT_W  = TAG_W + N_CORES + 1 + DATA_W;
  localparam int DEPTH  = 1 << IDX_W;

  fsm_t               state;
  logic [DEPTH-1:0]   vld_q;
  logic               lk_vld;
  logic [CORE_W-1:0]  r_core;
  logic               r_rfo;
  logic [TAG_W-1:0]   r_tag, vic_tag;
  logic [IDX_W-1:0]   r_idx;
  logic [N_CORES-1:0] req_oh, new_cvb_q;
  logic [DATA_W-1:0]  cur_data;
  logic               cur_dirty, evict_q;
  mesi_t              grant_q;

  logic [ENT_W-1:0]   rd_ent, wr_ent;
  logic [TAG_W-1:0]   lk_tag;
  logic [N_CORES-1:0] lk_cvb;
  logic               lk_dirty;
  logic [DATA_W-1:0]  lk_data;
  logic               rd_en, wr_en, hit;

  logic               pol_snoop, pol_inv;
  logic [N_CORES-1:0] pol_mask, pol_cvb;
  mesi_t              pol_grant;

  assign rd_en = (state == F_IDLE) && req_valid && req_ready;
  assign wr_en = (state == F_GO);
  assign wr_ent = {r_tag, new_cvb_q, cur_dirty, cur_data};
  assign {lk_tag, lk_cvb, lk_dirty, lk_data} = rd_ent;
  assign hit = lk_vld && (lk_tag == r_tag);

  always_comb begin
    req_oh = '0;
    req_oh[r_core] = 1'b1;
  end

  ccd_line_store #(.IDX_W(IDX_W), .WIDTH(ENT_W)) u_store (
    .clk(clk), .rd_en(rd_en), .rd_idx(req_addr[IDX_W-1:0]), .rd_data(rd_ent),
    .wr_en(wr_en), .wr_idx(r_idx), .wr_data(wr_ent)
  );

  ccd_policy #(.N_CORES(N_CORES)) u_pol (
    .hit(hit), .rfo(r_rfo), .req_oh(req_oh), .cvb(lk_cvb),
    .snoop(pol_snoop), .mask(pol_mask), .inv(pol_inv),
    .grant(pol_grant), .new_cvb(pol_cvb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= F_IDLE;
      vld_q        <= '0;
      req_ready    <= 1'b1;
      snp_valid    <= 1'b0;
      mem_rd_valid <= 1'b0;
      mem_wb_valid <= 1'b0;
      go_valid     <= 1'b0;
      fill_valid   <= 1'b0;
      evict_q      <= 1'b0;
    end else begin
      snp_valid    <= 1'b0;
      mem_rd_valid <= 1'b0;
      mem_wb_valid <= 1'b0;
      go_valid     <= 1'b0;
      fill_valid   <= 1'b0;
      case (state)
        F_IDLE: if (req_valid && req_ready) begin
          r_core    <= req_core;
          r_rfo     <= req_rfo;
          r_tag     <= req_addr[ADDR_W-1:IDX_W];
          r_idx     <= req_addr[IDX_W-1:0];
          lk_vld    <= vld_q[req_addr[IDX_W-1:0]];
          req_ready <= 1'b0;
          state     <= F_LOOK;
        end
        F_LOOK: begin
          cur_data  <= lk_data;
          cur_dirty <= lk_vld && lk_dirty;
          new_cvb_q <= pol_cvb;
          grant_q   <= pol_grant;
          vic_tag   <= lk_tag;
          if (hit) begin
            if (pol_snoop) begin
              snp_valid <= 1'b1;
              snp_addr  <= {r_tag, r_idx};
              snp_mask  <= pol_mask;
              snp_inv   <= pol_inv;
              evict_q   <= 1'b0;
              state     <= F_SNPW;
            end else begin
              state <= F_GO;
            end
          end else if (lk_vld && (lk_cvb != '0)) begin
            snp_valid <= 1'b1;
            snp_addr  <= {lk_tag, r_idx};
            snp_mask  <= lk_cvb;
            snp_inv   <= 1'b1;
            evict_q   <= 1'b1;
            state     <= F_SNPW;
          end else if (lk_vld && lk_dirty) begin
            mem_wb_valid <= 1'b1;
            mem_wb_addr  <= {lk_tag, r_idx};
            mem_wb_data  <= lk_data;
            state        <= F_WB;
          end else begin
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= {r_tag, r_idx};
            state        <= F_MRDW;
          end
        end
        F_SNPW: if (snp_ack) begin
          if (snp_dirty) begin
            cur_data  <= snp_data;
            cur_dirty <= 1'b1;
          end
          if (!evict_q) begin
            state <= F_GO;
          end else if (snp_dirty || cur_dirty) begin
            mem_wb_valid <= 1'b1;
            mem_wb_addr  <= {vic_tag, r_idx};
            mem_wb_data  <= snp_dirty ? snp_data : cur_data;
            state        <= F_WB;
          end else begin
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= {r_tag, r_idx};
            state        <= F_MRDW;
          end
        end
        F_WB: begin
          mem_rd_valid <= 1'b1;
          mem_rd_addr  <= {r_tag, r_idx};
          state        <= F_MRDW;
        end
        F_MRDW: if (mem_rd_done) begin
          cur_data  <= mem_rd_data;
          cur_dirty <= 1'b0;
          state     <= F_GO;
        end
        F_GO: begin
          go_valid     <= 1'b1;
          go_core      <= r_core;
          go_state     <= grant_q;
          vld_q[r_idx] <= 1'b1;
          state        <= F_FILL;
        end
        F_FILL: begin
          fill_valid <= 1'b1;
          fill_core  <= r_core;
          fill_data  <= cur_data;
          req_ready  <= 1'b1;
          state      <= F_IDLE;
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  AST_SNOOP_NOT_SELF: assert property (@(posedge clk) disable iff (rst)
    snp_valid && !evict_q |-> (snp_mask & req_oh) == '0); // R3
  AST_SNOOP_TARGETED: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> snp_mask != '0); // R5
  AST_EVICT_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
    snp_valid && evict_q |-> snp_inv); // R7
  AST_MEM_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !mem_wb_valid); // R7
  AST_GO_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
    go_valid |=> fill_valid && fill_core == $past(go_core)); // R8
  AST_OWNER_ALONE: assert property (@(posedge clk) disable iff (rst)
    go_valid && (go_state == ST_E || go_state == ST_M) |-> $countones($past(new_cvb_q)) == 1); // R2
  AST_SHARED_MANY: assert property (@(posedge clk) disable iff (rst)
    go_valid && go_state == ST_S |-> $countones($past(new_cvb_q)) >= 2); // R4
endmodule

// File: tb/sim_ccd_directory.sv
`timescale 1ns/1ps
module sim_ccd_directory;
  localparam int N = 4, IW = 4, TW = 6, DW = 32, CW = 2, AW = 10;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready, req_rfo = 0;
  logic [CW-1:0] req_core = 0;
  logic [AW-1:0] req_addr = 0;
  logic snp_valid, snp_inv, snp_ack = 0, snp_dirty = 0;
  logic [AW-1:0] snp_addr, mem_rd_addr, mem_wb_addr;
  logic [N-1:0] snp_mask;
  logic [DW-1:0] snp_data = 0, mem_rd_data = 0, mem_wb_data, fill_data;
  logic mem_rd_valid, mem_rd_done = 0, mem_wb_valid, go_valid, fill_valid;
  logic [CW-1:0] go_core, fill_core;
  logic [1:0] go_state;

  always #4 clk = ~clk;

  ccd_directory #(.N_CORES(N), .IDX_W(IW), .TAG_W(TW), .DATA_W(DW)) u0 (.*);

  int checks = 0, fails = 0, done_cnt = 0, issued = 0;
  int snp_cnt = 0, wb_cnt = 0, rd_cnt = 0;
  logic [N-1:0] l_mask; logic l_inv;
  logic [AW-1:0] l_saddr, l_wb_addr, l_rd_addr;
  logic [DW-1:0] l_wb_data;
  bit plan_dirty = 0; logic [DW-1:0] plan_data = 0;
  logic [CW-1:0] q_core[$]; logic [1:0] q_st[$]; logic [DW-1:0] q_data[$];
  bit fill_pend = 0; logic [CW-1:0] f_core; logic [DW-1:0] f_data;
  bit finished = 0;

  function automatic logic [DW-1:0] memval(logic [AW-1:0] a);
    return 32'h1000_0000 | DW'(a);
  endfunction

  task automatic chk(bit ok, string r, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // snoop responder
  initial forever begin
    @(negedge clk);
    if (snp_valid) begin
      snp_cnt++; l_mask = snp_mask; l_inv = snp_inv; l_saddr = snp_addr;
      repeat (2) @(negedge clk);
      snp_ack = 1; snp_dirty = plan_dirty; snp_data = plan_data;
      @(negedge clk);
      snp_ack = 0; snp_dirty = 0;
    end
  end

  // memory model
  initial forever begin
    @(negedge clk);
    if (mem_wb_valid) begin
      wb_cnt++; l_wb_addr = mem_wb_addr; l_wb_data = mem_wb_data;
    end
    if (mem_rd_valid) begin
      rd_cnt++; l_rd_addr = mem_rd_addr;
      repeat (3) @(negedge clk);
      mem_rd_done = 1; mem_rd_data = memval(l_rd_addr);
      @(negedge clk);
      mem_rd_done = 0;
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (fill_pend) begin
      chk(fill_valid === 1'b1, "R8 fill pulse", fill_valid, 1);
      chk(fill_core === f_core, "R8 fill core", fill_core, f_core);
      chk(fill_data === f_data, "R2/R3 fill data", fill_data, f_data);
      fill_pend = 0;
      done_cnt++;
    end
    if (go_valid) begin
      if (q_core.size() == 0) chk(0, "R8 unexpected GO", 1, 0);
      else begin
        f_core = q_core.pop_front(); f_data = q_data.pop_front();
        chk(go_core === f_core, "R8 GO core", go_core, f_core);
        chk(go_state === q_st[0], "R2-grant state", go_state, q_st[0]);
        void'(q_st.pop_front());
        fill_pend = 1;
      end
    end
  end

  task automatic do_req(int core, bit rfo, logic [AW-1:0] a, logic [1:0] st, logic [DW-1:0] d);
    q_core.push_back(CW'(core)); q_st.push_back(st); q_data.push_back(d);
    issued++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_core = CW'(core); req_rfo = rfo; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready === 1'b0, "R9 busy after accept", req_ready, 0);
    while (done_cnt != issued) begin
      if (!fill_pend) chk(req_ready === 1'b0, "R9 ready held low", req_ready, 0);
      @(negedge clk);
    end
  endtask

  task automatic chk_snp(int s0, int dn, logic [N-1:0] m, bit inv, logic [AW-1:0] a, string r);
    chk(snp_cnt - s0 == dn, {r, " snoop count"}, snp_cnt - s0, dn);
    if (dn != 0) begin
      chk(l_mask === m, {r, " snoop mask"}, l_mask, m);
      chk(l_inv === inv, {r, " snoop kind"}, l_inv, inv);
      chk(l_saddr === a, {r, " snoop addr"}, l_saddr, a);
    end
  endtask

  initial begin
    int s0, w0, r0;
    logic [AW-1:0] A, B, C, D, E;
    A = 10'h013; B = 10'h023; C = 10'h015; D = 10'h025; E = 10'h037;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(req_ready === 1, "R1 ready", req_ready, 1);
    chk(go_valid === 0 && fill_valid === 0, "R1 no response", go_valid, 0);
    chk(snp_valid === 0, "R1 no snoop", snp_valid, 0);
    chk(mem_rd_valid === 0 && mem_wb_valid === 0, "R1 no memory op", mem_rd_valid, 0);

    // R2: cold read miss by core 0
    s0 = snp_cnt; r0 = rd_cnt;
    do_req(0, 0, A, 2'd2, memval(A));
    chk(rd_cnt - r0 == 1 && l_rd_addr === A, "R2 memory read", l_rd_addr, A);
    chk_snp(s0, 0, 0, 0, 0, "R1");

    // R3: single other holder, returns dirty data
    plan_dirty = 1; plan_data = 32'hDEAD_0001; s0 = snp_cnt;
    do_req(1, 0, A, 2'd1, 32'hDEAD_0001);
    chk_snp(s0, 1, 4'b0001, 0, A, "R3");

    // R4: two other holders, no snoop
    plan_dirty = 0; s0 = snp_cnt;
    do_req(2, 0, A, 2'd1, 32'hDEAD_0001);
    chk_snp(s0, 0, 0, 0, 0, "R4");

    // R5: ownership request invalidates all others
    s0 = snp_cnt;
    do_req(3, 1, A, 2'd3, 32'hDEAD_0001);
    chk_snp(s0, 1, 4'b0111, 1, A, "R5");

    // R6: hit, sole holder, read gets E
    s0 = snp_cnt;
    do_req(3, 0, A, 2'd2, 32'hDEAD_0001);
    chk_snp(s0, 0, 0, 0, 0, "R6");

    // R5 follow-up: only core 3 remained
    plan_dirty = 1; plan_data = 32'hBEEF_0003; s0 = snp_cnt;
    do_req(0, 0, A, 2'd1, 32'hBEEF_0003);
    chk_snp(s0, 1, 4'b1000, 0, A, "R5");

    plan_dirty = 0; s0 = snp_cnt;
    do_req(1, 1, A, 2'd3, 32'hBEEF_0003);
    chk_snp(s0, 1, 4'b1001, 1, A, "R5");

    // R7: dirty eviction
    plan_dirty = 1; plan_data = 32'hCAFE_0005; s0 = snp_cnt; w0 = wb_cnt; r0 = rd_cnt;
    do_req(2, 0, B, 2'd2, memval(B));
    chk_snp(s0, 1, 4'b0010, 1, A, "R7");
    chk(wb_cnt - w0 == 1, "R7 writeback count", wb_cnt - w0, 1);
    chk(l_wb_addr === A, "R7 writeback addr", l_wb_addr, A);
    chk(l_wb_data === 32'hCAFE_0005, "R7 writeback data", l_wb_data, 32'hCAFE_0005);
    chk(rd_cnt - r0 == 1 && l_rd_addr === B, "R7 read new line", l_rd_addr, B);

    // R7: clean eviction, no writeback
    plan_dirty = 0;
    do_req(0, 0, C, 2'd2, memval(C));
    s0 = snp_cnt; w0 = wb_cnt;
    do_req(0, 0, D, 2'd2, memval(D));
    chk_snp(s0, 1, 4'b0001, 1, C, "R7");
    chk(wb_cnt == w0, "R7 clean victim no writeback", wb_cnt - w0, 0);
    chk(l_rd_addr === D, "R7 read after clean evict", l_rd_addr, D);

    // R5: ownership miss granted M
    s0 = snp_cnt;
    do_req(1, 1, E, 2'd3, memval(E));
    chk_snp(s0, 0, 0, 0, 0, "R5");

    // R6: ownership hit with sole holder
    s0 = snp_cnt;
    do_req(1, 1, E, 2'd3, memval(E));
    chk_snp(s0, 0, 0, 0, 0, "R6");

    repeat (4) @(negedge clk);
    chk(q_core.size() == 0, "R8 all responses seen", q_core.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, issued);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule